// File: doc/BRIEF.md
# Banked Register-Memory Address Generator

This block forms the read and write addresses for a 256-word register memory. An instruction carries only a 4-bit register field. A 4-bit region register supplies the upper half of the address, so each instruction reaches one of sixteen 16-word regions. One instruction may read and write the register memory. Normally it writes the word it reads. An 8-bit special-function field in the same instruction can move the write to a different word. It either swaps in new low write bits, which stay in the current region, or swaps in a new region for the write alone.

The region register changes in two ways. A load function copies a supplied region number into it, and the new value applies from the next instruction. A task-entry input forces it to region 0 or region 1 at the first instruction of a new opcode, and that first instruction already uses the forced region. When the instruction's stack-select bit is set, its 4-bit field names a stack operation and not a register. In that case no register-memory read is issued. A register-memory write is allowed only when a low-bits override supplies the word to write.

Top module: `rm_bank_addr_gen`

## Requirements
- R1: After reset the region register holds 0, so the first instruction without task entry reads address {0, field}.
- R2: rd_addr is the current region in bits [7:4] with the instruction's 4-bit register field in bits [3:0].
- R3: For function codes 0x00-0x1F and 0x41-0xFF, wr_addr equals rd_addr.
- R4: For function codes 0x20-0x2F, wr_addr[3:0] is the function's low 4 bits and wr_addr[7:4] is the current region. rd_addr is unchanged.
- R5: For function codes 0x30-0x3F, wr_addr[7:4] is the function's low 4 bits and wr_addr[3:0] is the register field. rd_addr and the stored region are unchanged.
- R6: Function code 0x40 on a valid instruction loads the region register from load_val. The same instruction still uses the old region, and the next instruction uses the new one.
- R7: A valid instruction with task_entry high uses region {000, entry_rgn} for its own addresses, and keeps that region for the instructions after it.
- R8: When task entry and the load function (0x40) occur in one instruction, that instruction uses the entry region, and load_val is the region held afterwards.
- R9: rd_en = instr_valid & instr_rd & ~instr_stack. wr_en = instr_valid & instr_wr & (~instr_stack | function in 0x20-0x2F).
- R10: While instr_valid is low, both enables are low and the region register keeps its value whatever the function field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr_stack | input | 1 | Register field encodes a stack operation |
| instr_rd | input | 1 | Instruction reads register memory |
| instr_wr | input | 1 | Instruction writes register memory |
| instr_raddr | input | 4 | Low register-address field |
| func | input | 8 | Special-function code |
| load_val | input | 4 | Region number for the load function |
| task_entry | input | 1 | First instruction of a new opcode |
| entry_rgn | input | 1 | Region forced on task entry (0 or 1) |
| rd_addr | output | 8 | Register-memory read address |
| rd_en | output | 1 | Read enable |
| wr_addr | output | 8 | Register-memory write address |
| wr_en | output | 1 | Write enable |

## Verification
The bench builds the block with its default parameters: a 4-bit field, a 4-bit region, an 8-bit function code, a 1-bit entry select and entry bypass on. These values make the exact code edges reachable, namely 0x1F, 0x20, 0x2F, 0x30, 0x3F, 0x40 and 0x41, as well as the all-ones field and region values. They also allow sequences in which a load, a task entry and an idle cycle act on the region register one after another.

// File: rtl/rm_bank_addr_pkg.sv
package rm_bank_addr_pkg;

   // decoded special-function class
   typedef struct packed {
      logic low_ovr;   // replace write low bits
      logic rgn_ovr;   // replace write region bits
      logic load;      // load region register
   } fn_class_t;

endpackage

// File: rtl/rm_fn_decode.sv
module rm_fn_decode
   import rm_bank_addr_pkg::*;
#(
   parameter int FW           = 8,
   parameter int LO_W         = 4,
   parameter int LOW_OVR_PAGE = 2,
   parameter int RGN_OVR_PAGE = 3,
   parameter int LOAD_CODE    = 'h40
) (
   input  logic          valid,
   input  logic [FW-1:0] func,
   output fn_class_t     cls
);
   localparam int PW = FW - LO_W;
   localparam logic [PW-1:0] LOW_P = PW'(LOW_OVR_PAGE);
   localparam logic [PW-1:0] RGN_P = PW'(RGN_OVR_PAGE);
   localparam logic [FW-1:0] LD_C  = FW'(LOAD_CODE);

   logic [PW-1:0] page;
   assign page = func[FW-1:LO_W];

   always_comb begin
      cls.low_ovr = valid && (page == LOW_P);
      cls.rgn_ovr = valid && (page == RGN_P);
      cls.load    = valid && (func == LD_C);
   end
endmodule

// File: rtl/rm_region_reg.sv
module rm_region_reg #(
   parameter int HI_W         = 4,
   parameter int ES_W         = 1,
   parameter bit ENTRY_BYPASS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic            load,
   input  logic [HI_W-1:0] load_val,
   input  logic            entry,
   input  logic [ES_W-1:0] entry_rgn,
   output logic [HI_W-1:0] cur_rgn
);
   logic [HI_W-1:0] rgn_q;
   logic [HI_W-1:0] entry_val;
   logic            entry_now;

   assign entry_val = HI_W'(entry_rgn);
   assign entry_now = valid && entry;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rgn_q <= '0;
      else if (load)
         rgn_q <= load_val;
      else if (entry_now)
         rgn_q <= entry_val;
   end

   generate
      if (ENTRY_BYPASS) begin : g_bypass
         assign cur_rgn = entry_now ? entry_val : rgn_q;
      end else begin : g_registered
         assign cur_rgn = rgn_q;
      end
   endgenerate
endmodule

// File: rtl/rm_addr_form.sv
module rm_addr_form
   import rm_bank_addr_pkg::*;
#(
   parameter int LO_W = 4,
   parameter int HI_W = 4,
   parameter int FW   = 8
) (
   input  logic               valid,
   input  logic               stack,
   input  logic               rd,
   input  logic               wr,
   input  logic [LO_W-1:0]    raddr,
   input  logic [FW-1:0]      func,
   input  fn_class_t          cls,
   input  logic [HI_W-1:0]    cur_rgn,
   output logic [HI_W+LO_W-1:0] rd_addr,
   output logic                 rd_en,
   output logic [HI_W+LO_W-1:0] wr_addr,
   output logic                 wr_en
);
   logic [LO_W-1:0] wr_lo;
   logic [HI_W-1:0] wr_hi;

   always_comb begin
      wr_lo   = cls.low_ovr ? func[LO_W-1:0] : raddr;
      wr_hi   = cls.rgn_ovr ? func[HI_W-1:0] : cur_rgn;
      rd_addr = {cur_rgn, raddr};
      wr_addr = {wr_hi, wr_lo};
      rd_en   = valid && rd && !stack;
      wr_en   = valid && wr && (!stack || cls.low_ovr);
   end
endmodule

// File: rtl/rm_bank_addr_gen.sv
module rm_bank_addr_gen
   import rm_bank_addr_pkg::*;
#(
   parameter int LO_W         = 4,
   parameter int HI_W         = 4,
   parameter int FW           = 8,
   parameter int ES_W         = 1,
   parameter int LOW_OVR_PAGE = 2,
   parameter int RGN_OVR_PAGE = 3,
   parameter int LOAD_CODE    = 'h40,
   parameter bit ENTRY_BYPASS = 1'b1,
   localparam int AW          = LO_W + HI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic            instr_stack,
   input  logic            instr_rd,
   input  logic            instr_wr,
   input  logic [LO_W-1:0] instr_raddr,
   input  logic [FW-1:0]   func,
   input  logic [HI_W-1:0] load_val,
   input  logic            task_entry,
   input  logic [ES_W-1:0] entry_rgn,
   output logic [AW-1:0]   rd_addr,
   output logic            rd_en,
   output logic [AW-1:0]   wr_addr,
   output logic            wr_en
);
   generate
      if (HI_W > LO_W) begin : g_bad_hi
         $error("region width must fit the function low field");
      end
      if (LO_W >= FW) begin : g_bad_fw
         $error("function field must be wider than register field");
      end
      if (ES_W > HI_W) begin : g_bad_es
         $error("entry select wider than region");
      end
      if (LOW_OVR_PAGE == RGN_OVR_PAGE) begin : g_bad_page
         $error("override pages must differ");
      end
   endgenerate

   fn_class_t       cls;
   logic [HI_W-1:0] cur_rgn;

   rm_fn_decode #(
      .FW(FW), .LO_W(LO_W), .LOW_OVR_PAGE(LOW_OVR_PAGE),
      .RGN_OVR_PAGE(RGN_OVR_PAGE), .LOAD_CODE(LOAD_CODE)
   ) u_dec (
      .valid(instr_valid), .func(func), .cls(cls)
   );

   rm_region_reg #(
      .HI_W(HI_W), .ES_W(ES_W), .ENTRY_BYPASS(ENTRY_BYPASS)
   ) u_rgn (
      .clk(clk), .rst_n(rst_n), .valid(instr_valid), .load(cls.load),
      .load_val(load_val), .entry(task_entry), .entry_rgn(entry_rgn),
      .cur_rgn(cur_rgn)
   );

   rm_addr_form #(
      .LO_W(LO_W), .HI_W(HI_W), .FW(FW)
   ) u_form (
      .valid(instr_valid), .stack(instr_stack), .rd(instr_rd), .wr(instr_wr),
      .raddr(instr_raddr), .func(func), .cls(cls), .cur_rgn(cur_rgn),
      .rd_addr(rd_addr), .rd_en(rd_en), .wr_addr(wr_addr), .wr_en(wr_en)
   );
endmodule

// File: rtl/rm_bank_addr_chk.sv
module rm_bank_addr_chk #(
   parameter int LO_W         = 4,
   parameter int HI_W         = 4,
   parameter int FW           = 8,
   parameter int ES_W         = 1,
   parameter int LOW_OVR_PAGE = 2,
   parameter int RGN_OVR_PAGE = 3,
   parameter int LOAD_CODE    = 'h40,
   localparam int AW          = LO_W + HI_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic            instr_stack,
   input logic            instr_rd,
   input logic            instr_wr,
   input logic [LO_W-1:0] instr_raddr,
   input logic [FW-1:0]   func,
   input logic [HI_W-1:0] load_val,
   input logic            task_entry,
   input logic [ES_W-1:0] entry_rgn,
   input logic [AW-1:0]   rd_addr,
   input logic            rd_en,
   input logic [AW-1:0]   wr_addr,
   input logic            wr_en
);
   localparam int PW = FW - LO_W;
   logic in_low, in_rgn, is_load;
   assign in_low  = func[FW-1:LO_W] == PW'(LOW_OVR_PAGE);
   assign in_rgn  = func[FW-1:LO_W] == PW'(RGN_OVR_PAGE);
   assign is_load = func == FW'(LOAD_CODE);

   // R2
   rd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr[LO_W-1:0] == instr_raddr);
   // R3
   default_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !in_low && !in_rgn) |-> wr_addr == rd_addr);
   // R4
   low_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && in_low) |->
         (wr_addr[AW-1:LO_W] == rd_addr[AW-1:LO_W]) &&
         (wr_addr[LO_W-1:0] == func[LO_W-1:0]));
   // R5
   rgn_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && in_rgn) |->
         (wr_addr[LO_W-1:0] == instr_raddr) &&
         (wr_addr[AW-1:LO_W] == func[HI_W-1:0]));
   // R6
   load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && is_load) |=>
         ((instr_valid && task_entry) || rd_addr[AW-1:LO_W] == $past(load_val)));
   // R9
   stack_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_stack |-> !rd_en);
   // R9
   stack_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_stack && !in_low) |-> !wr_en);
   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!rd_en && !wr_en));
endmodule

bind rm_bank_addr_gen rm_bank_addr_chk #(
   .LO_W(LO_W), .HI_W(HI_W), .FW(FW), .ES_W(ES_W),
   .LOW_OVR_PAGE(LOW_OVR_PAGE), .RGN_OVR_PAGE(RGN_OVR_PAGE),
   .LOAD_CODE(LOAD_CODE)
) u_chk (.*);

// File: tb/rm_bank_addr_gen_bench.sv
`timescale 1ns/1ps
module rm_bank_addr_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       instr_valid, instr_stack, instr_rd, instr_wr;
   logic [3:0] instr_raddr;
   logic [7:0] func;
   logic [3:0] load_val;
   logic       task_entry;
   logic [0:0] entry_rgn;
   logic [7:0] rd_addr, wr_addr;
   logic       rd_en, wr_en;

   int checks = 0;
   int errors = 0;
   logic [3:0] m_rgn;

   always #2.5 clk = ~clk;

   rm_bank_addr_gen u_rm_bank_addr_gen (.*);

   // valid,stack,rd,wr,raddr[4],func[8],load_val[4],entry,ergn = 22 bits
   localparam int NV = 17;
   localparam logic [21:0] TBL [NV] = '{
      {4'b1011, 4'h5, 8'h00, 4'h0, 2'b00},  // R2 R3 default
      {4'b1011, 4'h3, 8'h27, 4'h0, 2'b00},  // R4
      {4'b1011, 4'h9, 8'h3A, 4'h0, 2'b00},  // R5
      {4'b1011, 4'h1, 8'h40, 4'h6, 2'b00},  // R6 load, old region used
      {4'b1011, 4'h2, 8'h10, 4'h0, 2'b00},  // R6 new region 6
      {4'b1011, 4'hE, 8'h41, 4'h0, 2'b00},  // R3 code 0x41
      {4'b1011, 4'h7, 8'h1F, 4'h0, 2'b00},  // R3 code 0x1F
      {4'b1111, 4'h4, 8'h00, 4'h0, 2'b00},  // R9 stack, no RM access
      {4'b1101, 4'h4, 8'h2C, 4'h0, 2'b00},  // R9 stack read, RM write
      {4'b1111, 4'h4, 8'h3B, 4'h0, 2'b00},  // R9 region override alone
      {4'b0011, 4'h8, 8'h40, 4'hF, 2'b11},  // R10 idle with load/entry
      {4'b1011, 4'h8, 8'h00, 4'h0, 2'b00},  // R10 region still 6
      {4'b1011, 4'hA, 8'h00, 4'h0, 2'b11},  // R7 entry region 1
      {4'b1011, 4'hB, 8'h2F, 4'h0, 2'b00},  // R7 held, R4 edge 0x2F
      {4'b1011, 4'hF, 8'h40, 4'h9, 2'b10},  // R8 entry + load
      {4'b1011, 4'hF, 8'h30, 4'h0, 2'b00},  // R8 region 9, R5 edge 0x30
      {4'b1011, 4'h0, 8'h3F, 4'h0, 2'b00}   // R5 edge 0x3F
   };

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [21:0] v);
      {instr_valid, instr_stack, instr_rd, instr_wr, instr_raddr,
       func, load_val, task_entry, entry_rgn} = v;
   endtask

   // apply at negedge, check mid-low phase, advance model at posedge
   task automatic step_check(input logic [21:0] v);
      logic [3:0] cur;
      logic [7:0] e_rd, e_wr;
      logic       lo, rg, e_re, e_we;
      @(negedge clk);
      drive(v);
      #1;
      cur  = (instr_valid && task_entry) ? {3'b000, entry_rgn} : m_rgn;
      lo   = func[7:4] == 4'h2;
      rg   = func[7:4] == 4'h3;
      e_rd = {cur, instr_raddr};
      e_wr = lo ? {cur, func[3:0]} : rg ? {func[3:0], instr_raddr} : e_rd;
      e_re = instr_valid && instr_rd && !instr_stack;
      e_we = instr_valid && instr_wr && (!instr_stack || lo);
      chk(task_entry ? "R7" : "R2", "rd_addr", rd_addr, e_rd);
      if (instr_valid)
         chk(lo ? "R4" : rg ? "R5" : "R3", "wr_addr", wr_addr, e_wr);
      chk(instr_valid ? "R9" : "R10", "rd_en", {7'b0, rd_en}, {7'b0, e_re});
      chk(instr_valid ? "R9" : "R10", "wr_en", {7'b0, wr_en}, {7'b0, e_we});
      @(posedge clk);
      if (instr_valid) begin
         if (func == 8'h40) m_rgn = load_val;
         else if (task_entry) m_rgn = {3'b000, entry_rgn};
      end
   endtask

   initial begin
      #20000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(22'd0);
      m_rgn = 4'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state: region 0, outputs idle
      #1;
      chk("R1", "rd_addr after reset", rd_addr, 8'h00);
      chk("R1", "enables after reset", {6'b0, rd_en, wr_en}, 8'h00);
      step_check({4'b1011, 4'hC, 8'h00, 4'h0, 2'b00});
      chk("R1", "first read region", rd_addr, 8'h0C);

      for (int i = 0; i < NV; i++) step_check(TBL[i]);

      // R6 directed: back-to-back loads, each seen one instruction later
      step_check({4'b1011, 4'h1, 8'h40, 4'hF, 2'b00});
      step_check({4'b1011, 4'h2, 8'h40, 4'h3, 2'b00});
      @(negedge clk);
      drive({4'b1011, 4'h2, 8'h00, 4'h0, 2'b00});
      #1;
      chk("R6", "second load visible", rd_addr, 8'h32);
      // R7 directed: entry to region 0 overrides current region at once
      step_check({4'b1011, 4'h5, 8'h00, 4'h0, 2'b10});
      @(negedge clk);
      drive({4'b1011, 4'h5, 8'h00, 4'h0, 2'b00});
      #1;
      chk("R7", "entry region kept", rd_addr, 8'h05);
      // R10 directed: idle cycles leave region unchanged
      step_check({4'b0011, 4'h1, 8'h40, 4'hA, 2'b11});
      step_check({4'b0000, 4'h1, 8'h00, 4'h0, 2'b11});
      @(negedge clk);
      drive({4'b1011, 4'h1, 8'h00, 4'h0, 2'b00});
      #1;
      chk("R10", "region after idle", rd_addr, 8'h01);
      // R1 directed: reset mid-run clears region
      @(negedge clk);
      drive({4'b1011, 4'h0, 8'h40, 4'h7, 2'b00});
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      drive({4'b1011, 4'h6, 8'h00, 4'h0, 2'b00});
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "region after re-reset", rd_addr, 8'h06);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule